// File: doc/BRIEF.md
# Physical memory protection access checker

This block rules on whether a single memory access may proceed. The access is described by its byte address, its size, the set of read, write and execute rights it asks for, and whether the hart is running in machine mode. The block takes sixteen protection entries from a register bank elsewhere. Each entry is a configuration byte and an address register. It works out the byte range each entry covers and picks the lowest-numbered entry that the access touches. It then returns one grant bit in the same cycle, with no clock and no state.

The caller drives the access fields and the flattened entry fields. It reads `grant` after the combinational path settles. Register storage, trap raising and address translation belong to neighbouring blocks.

Top module: `pmp_check`

## Requirements
- R1: When every entry's mode field (configuration bits 4:3) is 0 (off), `grant` is 1 for any access at any privilege level.
- R2: Entries are ranked by index, and the lowest-numbered entry that holds the first or the last byte of the access alone decides the result. Off entries never match.
- R3: If exactly one of the access's first and last bytes lies inside the deciding entry's range, the access is denied.
- R4: For a fully matching entry, a machine-mode access (`acc_mmode`=1) gets read, write and execute rights when the entry's lock bit (configuration bit 7) is 0. Otherwise the rights are configuration bit 0 (read), bit 1 (write) and bit 2 (execute).
- R5: A full match grants only when every bit set in `acc_req` (bit 0 read, bit 1 write, bit 2 execute) is also set in the allowed rights.
- R6: When at least one entry is active and none matches, `grant` equals `acc_mmode`.
- R7: In mode 1 (top of range), the entry covers bytes from the previous entry's address register times 4 up to this entry's register times 4 minus 1. Entry 0 starts at byte 0, and a range whose start is not below its end is empty.
- R8: In mode 2, the entry covers the four bytes starting at its address register times 4.
- R9: In mode 3, t trailing ones in the address register give a region of 2^(t+3) bytes. The region's base is the register times 4 with the low t+3 bits cleared. An all-ones register covers the whole address space.
- R10: `acc_size` values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The last byte is the address plus the byte count minus 1, computed without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | PAW | Byte address of the access |
| acc_size | input | 2 | Log2 of the access size in bytes |
| acc_req | input | 3 | Requested rights: read, write, execute |
| acc_mmode | input | 1 | 1 when the access is made in machine mode |
| ent_cfg | input | NENT*8 | Configuration byte of each entry, entry i at bits 8i+7:8i |
| ent_addr | input | NENT*(PAW-2) | Address register of each entry, entry i in slice i |
| grant | output | 1 | 1 when the access is permitted |

## Verification
The hard case is an access where the straddle rule and the priority rule apply at once. A wide access's first byte can lie in a low-numbered entry while its last byte lies in a higher one, so the partial overlap must win over the permissions that the higher entry would grant. The sweeps provoke this with adjacent and nested regions, every access size and every start address around the region edges. Each result is compared with a model that computes ranges by counting bits and rejects any straddle before it looks at rights. Machine mode is swept against locked and unlocked entries in the same configurations, so the rights override is tested on the same edges.

// File: rtl/pmp_check.sv
module pmp_check #(
  parameter int NENT = 16,
  parameter int PAW  = 32
) (
  input  logic [PAW-1:0]          acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [2:0]              acc_req,
  input  logic                    acc_mmode,
  input  logic [NENT*8-1:0]       ent_cfg,
  input  logic [NENT*(PAW-2)-1:0] ent_addr,
  output logic                    grant
);
  localparam int ARW = PAW - 2;
  localparam int RW  = PAW + 2;

  logic [RW-1:0] first_b, last_b;
  assign first_b = RW'(acc_addr);
  assign last_b  = first_b + (RW'(1) << acc_size) - RW'(1);

  logic [NENT-1:0] act, hit, ok;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic [7:0]     cfg;
    logic [ARW-1:0] ar, prv;
    logic [ARW:0]   ones;
    logic [RW-1:0]  nap_mask, nap_lo, lo, hi;
    logic [2:0]     allow;
    logic           in_f, in_l;

    assign cfg = ent_cfg[i*8 +: 8];
    assign ar  = ent_addr[i*ARW +: ARW];
    if (i == 0) begin : g_first
      assign prv = '0;
    end else begin : g_rest
      assign prv = ent_addr[(i-1)*ARW +: ARW];
    end

    assign ones     = ({1'b0, ar} ^ ({1'b0, ar} + 1'b1)) >> 1;
    assign nap_mask = {ones, 3'b111};
    assign nap_lo   = {2'b00, ar, 2'b00} & ~nap_mask;

    always_comb begin
      case (cfg[4:3])
        2'd1: begin lo = {2'b00, prv, 2'b00}; hi = {2'b00, ar, 2'b00}; end
        2'd2: begin lo = {2'b00, ar, 2'b00};  hi = {2'b00, ar, 2'b00} + RW'(4); end
        2'd3: begin lo = nap_lo;              hi = nap_lo + nap_mask + RW'(1); end
        default: begin lo = '0; hi = '0; end
      endcase
    end

    assign act[i] = cfg[4:3] != 2'd0;
    assign in_f   = act[i] && first_b >= lo && first_b < hi;
    assign in_l   = act[i] && last_b >= lo && last_b < hi;
    assign hit[i] = in_f | in_l;
    assign allow  = (acc_mmode && !cfg[7]) ? 3'b111 : cfg[2:0];
    assign ok[i]  = !(in_f ^ in_l) && ((acc_req & ~allow) == 3'b000);
  end

  always_comb begin
    grant = (|act) ? acc_mmode : 1'b1;
    for (int k = NENT - 1; k >= 0; k--)
      if (hit[k]) grant = ok[k];
  end
endmodule

module pmp_check_sva #(
  parameter int NENT = 16,
  parameter int PAW  = 32
) (
  input logic [PAW-1:0]          acc_addr,
  input logic [1:0]              acc_size,
  input logic [2:0]              acc_req,
  input logic                    acc_mmode,
  input logic [NENT*8-1:0]       ent_cfg,
  input logic [NENT*(PAW-2)-1:0] ent_addr,
  input logic                    grant
);
  localparam int ARW = PAW - 2;

  logic       any_act;
  logic [2:0] perm_union;
  logic [7:0] c0;
  logic [ARW-1:0] a0;
  logic [2:0] eff0;

  always_comb begin
    any_act    = 1'b0;
    perm_union = 3'b000;
    for (int k = 0; k < NENT; k++)
      if (ent_cfg[k*8+3 +: 2] != 2'd0) begin
        any_act    = 1'b1;
        perm_union = perm_union | ent_cfg[k*8 +: 3];
      end
  end

  assign c0   = ent_cfg[7:0];
  assign a0   = ent_addr[ARW-1:0];
  assign eff0 = (acc_mmode && !c0[7]) ? 3'b111 : c0[2:0];

  always_comb begin
    // R1
    none_active_chk: assert (any_act || grant)
      else $error("grant low with no active entry");
    // R5
    user_rights_chk: assert (acc_mmode || !any_act || !grant || ((acc_req & ~perm_union) == 3'b000))
      else $error("user access granted rights no entry holds");
    // R3
    straddle_chk: assert (!(c0[4:3] == 2'd2 && acc_addr == {a0, 2'b11} && acc_size != 2'd0) || !grant)
      else $error("straddling access granted");
    // R9
    whole_space_chk: assert (!(c0[4:3] == 2'd3 && &a0) || (grant == ((acc_req & ~eff0) == 3'b000)))
      else $error("whole-space entry ruled wrongly");
  end
endmodule

bind pmp_check pmp_check_sva #(.NENT(NENT), .PAW(PAW)) u_sva (.*);

// File: tb/sim_pmp_check.sv
module sim_pmp_check;
  localparam int NENT = 16;
  localparam int PAW  = 32;
  localparam int ARW  = PAW - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [PAW-1:0] acc_addr;
  logic [1:0] acc_size;
  logic [2:0] acc_req;
  logic acc_mmode;
  logic [NENT-1:0][7:0] cfg;
  logic [NENT-1:0][ARW-1:0] ar;
  logic grant;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pmp_check #(.NENT(NENT), .PAW(PAW)) u0 (
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_req(acc_req),
    .acc_mmode(acc_mmode), .ent_cfg(cfg), .ent_addr(ar), .grant(grant)
  );

  function automatic void model(output bit g, output string why);
    longint unsigned f, l, lo, hi, sz;
    bit any, fi, la;
    int t;
    logic [2:0] allow;
    f = longint'(acc_addr);
    l = f + (longint'(1) << acc_size) - 1;
    any = 0;
    for (int i = 0; i < NENT; i++) if (cfg[i][4:3] != 0) any = 1;
    if (!any) begin g = 1; why = "R1"; return; end
    for (int i = 0; i < NENT; i++) begin
      case (cfg[i][4:3])
        2'd0: continue;
        2'd1: begin lo = (i == 0) ? 0 : longint'(ar[i-1]) * 4; hi = longint'(ar[i]) * 4; end
        2'd2: begin lo = longint'(ar[i]) * 4; hi = lo + 4; end
        default: begin
          t = 0;
          while (t < ARW && ar[i][t]) t++;
          sz = longint'(1) << (t + 3);
          lo = (longint'(ar[i]) * 4) & ~(sz - 1);
          hi = lo + sz;
        end
      endcase
      fi = (f >= lo) && (f < hi);
      la = (l >= lo) && (l < hi);
      if (fi != la) begin g = 0; why = "R3"; return; end
      if (fi) begin
        allow = (acc_mmode && !cfg[i][7]) ? 3'b111 : cfg[i][2:0];
        g = (acc_req & ~allow) == 0;
        why = (acc_mmode && !cfg[i][7]) ? "R4" : "R5";
        return;
      end
    end
    g = acc_mmode;
    why = "R6";
  endfunction

  task automatic sweep(input string tag, input longint base);
    bit g;
    string why;
    for (int a = 0; a < 128; a++)
      for (int s = 0; s < 4; s++)
        for (int q = 0; q < 8; q++)
          for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            acc_addr = PAW'(base + a);
            acc_size = 2'(s);
            acc_req = 3'(q);
            acc_mmode = m[0];
            #3;
            model(g, why);
            checks++;
            if (grant !== g) begin
              errors++;
              $display("FAIL %s/%s addr=%0h size=%0d req=%0d mm=%0d actual=%0b expected=%0b",
                       tag, why, acc_addr, s, q, m, grant, g);
            end
          end
  endtask

  task automatic clear();
    cfg = '0;
    ar = '0;
  endtask

  initial begin
    clear();
    acc_addr = '0; acc_size = 0; acc_req = 3'b111; acc_mmode = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    #3;
    checks++;
    if (grant !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state actual=%0b expected=1", grant);
    end
    // R1: nothing active
    sweep("R1", 0);
    // R7 top of range, R8 four-byte, lock on entry 1
    clear();
    ar[0] = 8;  cfg[0] = 8'h09;
    ar[1] = 16; cfg[1] = 8'h8B;
    ar[2] = 20; cfg[2] = 8'h14;
    sweep("R7", 0);
    // R9 power-of-two, R2 nested entry shadowed by lower index
    clear();
    ar[0] = 17; cfg[0] = 8'h9A;
    ar[1] = 7;  cfg[1] = 8'h1D;
    ar[2] = 2;  cfg[2] = 8'h17;
    sweep("R9", 0);
    // R2 lower entry with no rights inside a wide one; empty TOR at entry 3
    clear();
    ar[0] = 4;  cfg[0] = 8'h10;
    ar[1] = 15; cfg[1] = 8'h1F;
    ar[2] = 30; ar[3] = 10; cfg[3] = 8'h0F;
    sweep("R2", 0);
    // R8 lone four-byte entry away from 0, R10 all sizes across its edges
    clear();
    ar[5] = 25; cfg[5] = 8'h13;
    sweep("R8", 0);
    // R9 all-ones register covers the whole space, locked, read only; top of memory
    clear();
    ar[0] = '1; cfg[0] = 8'h99;
    sweep("R9", 64'hFFFF_FF80);
    // R10 last byte computed without wrap near the top, TOR ending below it
    clear();
    ar[0] = '1; cfg[0] = 8'h0B;
    sweep("R10", 64'hFFFF_FF80);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule